// File: doc/BRIEF.md
# Dual Rolling Shutter Row Sequencer

The sequencer produces the per-row control strobes for a pixel array in which every row is captured twice in one frame: a short exposure parked on the pixel's storage node and a long exposure left on the photodiode. Two row pointers step through the array at the same row rate. The readout pointer selects its row and runs three sample phases: the stored short signal, then the reset level, then the long signal. The shutter pointer trails it by a programmable number of rows. It clears the storage node of its row and then transfers the photodiode charge into it. The row gap sets the short exposure. The remaining rows of the frame set the long exposure.

A frame begins on a frame start pulse and lasts exactly one slot per row. Each slot has a fixed length of 5*(PW_MAX+1) clocks. Inside a slot the five pulses follow a fixed order, and each pulse is followed by one idle clock. The row gap and the pulse width are captured when a frame is accepted and held until that frame ends. The three sample strobes tell the column converters when each level is settled. A frame-done strobe marks the wrap of the readout pointer.

Top module: `drs_row_seq`

## Requirements
- R1: After reset, and at all times while no frame is running, every row line, every sample strobe and the frame-done strobe is low.
- R2: A frame start sampled at clock edge E is accepted when no frame is running. The output state for slot k, offset t (0 <= t < S, where S = 5*(PW_MAX+1)) appears in the cycle that follows edge E+1+k*S+t. The readout row of slot k is row k, so all N_ROWS rows are visited once, starting at row 0. Let p be the accepted pulse width. On the readout row, SEL is high for t in [0, 3p+1], RST is high for t in [p+1, 2p], and TX is high for t in [2p+2, 3p+1].
- R3: The shutter row of slot k is (k - I) mod N_ROWS, where I is the accepted row gap. On that row, RST is high for t in [3p+3, 4p+2] and TX is high for t in [4p+4, 5p+3]. All readout pulses therefore end before any shutter pulse starts, each pulse is followed by at least one idle clock, and no more than one row of each line is high at a time.
- R4: RST and TX are never high in the same cycle.
- R5: The short-sample strobe is high only at t = p-1, the reset-sample strobe only at t = 2p, and the long-sample strobe only at t = 3p+1. Each is one cycle long, on the readout row, while SEL is high.
- R6: At acceptance, a row gap of 0 is taken as 1, and a gap above N_ROWS-1 is taken as N_ROWS-1. A pulse width of 0 is taken as 1, and a width above PW_MAX is taken as PW_MAX. Changes to either input while a frame runs have no effect on that frame.
- R7: A frame start while a frame runs is ignored. Frame-done is high for exactly the cycle of the last offset of slot N_ROWS-1. From the next cycle on, all outputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Start a frame when idle |
| interval_i | input | ROW_W | Row gap between readout and shutter pointers |
| pulse_w_i | input | PW_W | RST/TX/SEL pulse width in clocks |
| row_rst_o | output | N_ROWS | Per-row storage reset strobe |
| row_tx_o | output | N_ROWS | Per-row charge transfer strobe |
| row_sel_o | output | N_ROWS | Per-row select |
| smp_short_o | output | 1 | Sample short-exposure level |
| smp_reset_o | output | 1 | Sample reset level |
| smp_long_o | output | 1 | Sample long-exposure level |
| frame_done_o | output | 1 | Readout pointer wrap |

## Verification
The hardest case to reach from the ports is a frame start that arrives mid-frame together with a new row gap and pulse width. The block must both refuse the pulse and keep using the captured settings. The bench drives that case twenty cycles into a running frame and then compares every output on every cycle against an arithmetic model that uses the original settings. It also sweeps the row gap across its limits, including the wrap of the shutter pointer below row 0. It applies out-of-range gap and width codes and checks that the array is driven with the clamped values.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [2:0] {
    PH_RD_SIG = 3'd0,
    PH_RD_RST = 3'd1,
    PH_RD_TX  = 3'd2,
    PH_SH_RST = 3'd3,
    PH_SH_TX  = 3'd4,
    PH_IDLE   = 3'd5
  } phase_e;
endpackage

// File: rtl/drs_frame_ctrl.sv
module drs_frame_ctrl #(
  parameter int N_ROWS = 240,
  parameter int PW_MAX = 4,
  localparam int ROW_W = $clog2(N_ROWS),
  localparam int PW_W  = $clog2(PW_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ROW_W-1:0] interval_i,
  input  logic [PW_W-1:0]  pulse_w_i,
  input  logic             slot_end_i,
  input  logic             last_row_i,
  output logic             busy_o,
  output logic             start_o,
  output logic [ROW_W-1:0] iv_load_o,
  output logic [ROW_W-1:0] iv_o,
  output logic [PW_W-1:0]  pw_o,
  output logic             frame_done_o
);
  logic             busy_q, done_q;
  logic [ROW_W-1:0] iv_q;
  logic [PW_W-1:0]  pw_q, pw_c;

  assign start_o = start_i && !busy_q;

  always_comb begin
    if (interval_i == '0)                       iv_load_o = ROW_W'(1);
    else if (interval_i > ROW_W'(N_ROWS - 1))   iv_load_o = ROW_W'(N_ROWS - 1);
    else                                        iv_load_o = interval_i;
    if (pulse_w_i == '0)                        pw_c = PW_W'(1);
    else if (pulse_w_i > PW_W'(PW_MAX))         pw_c = PW_W'(PW_MAX);
    else                                        pw_c = pulse_w_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      iv_q   <= ROW_W'(1);
      pw_q   <= PW_W'(1);
    end else begin
      done_q <= busy_q && slot_end_i && last_row_i;
      if (start_o) begin
        busy_q <= 1'b1;
        iv_q   <= iv_load_o;
        pw_q   <= pw_c;
      end else if (busy_q && slot_end_i && last_row_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o       = busy_q;
  assign iv_o         = iv_q;
  assign pw_o         = pw_q;
  assign frame_done_o = done_q;

  // R6
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> ($stable(iv_q) && $stable(pw_q)));
  // R6
  cfg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (iv_q != '0 && iv_q <= ROW_W'(N_ROWS - 1) && pw_q != '0 && pw_q <= PW_W'(PW_MAX)));
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
endmodule

// File: rtl/drs_slot_timer.sv
module drs_slot_timer
  import drs_pkg::*;
#(
  parameter int PW_MAX = 4,
  localparam int PW_W      = $clog2(PW_MAX + 1),
  localparam int SLOT_CLKS = 5 * (PW_MAX + 1),
  localparam int T_W       = $clog2(SLOT_CLKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            busy_i,
  input  logic [PW_W-1:0] pw_i,
  output phase_e          ph_o,
  output logic [PW_W-1:0] cyc_o,
  output logic            slot_end_o
);
  logic [T_W-1:0]  t_q;
  logic [PW_W-1:0] cyc_q;
  phase_e          ph_q;

  assign slot_end_o = (t_q == T_W'(SLOT_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q   <= '0;
      cyc_q <= '0;
      ph_q  <= PH_RD_SIG;
    end else if (start_i || (busy_i && slot_end_o)) begin
      t_q   <= '0;
      cyc_q <= '0;
      ph_q  <= PH_RD_SIG;
    end else if (busy_i) begin
      t_q <= t_q + T_W'(1);
      if (ph_q != PH_IDLE) begin
        if (cyc_q == pw_i) begin
          cyc_q <= '0;
          ph_q  <= phase_e'(ph_q + 3'd1);
        end else begin
          cyc_q <= cyc_q + PW_W'(1);
        end
      end
    end
  end

  assign ph_o  = ph_q;
  assign cyc_o = cyc_q;

  // R3
  phase_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !slot_end_o) |=> (ph_q >= $past(ph_q)));
  // R2
  gap_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && ph_q != PH_IDLE) |-> (cyc_q <= pw_i));
endmodule

// File: rtl/drs_row_pointer.sv
module drs_row_pointer #(
  parameter int N_ROWS = 240,
  localparam int ROW_W = $clog2(N_ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic             slot_end_i,
  input  logic [ROW_W-1:0] iv_load_i,
  input  logic [ROW_W-1:0] iv_i,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [ROW_W-1:0] sh_row_o,
  output logic             last_row_o
);
  logic [ROW_W-1:0] rd_q, sh_q;

  function automatic logic [ROW_W-1:0] wrap_inc(input logic [ROW_W-1:0] v);
    return (v == ROW_W'(N_ROWS - 1)) ? '0 : v + ROW_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      sh_q <= '0;
    end else if (start_i) begin
      rd_q <= '0;
      sh_q <= ROW_W'(N_ROWS) - iv_load_i;
    end else if (busy_i && slot_end_i) begin
      rd_q <= wrap_inc(rd_q);
      sh_q <= wrap_inc(sh_q);
    end
  end

  assign rd_row_o   = rd_q;
  assign sh_row_o   = sh_q;
  assign last_row_o = (rd_q == ROW_W'(N_ROWS - 1));

  logic [ROW_W:0] gap_sum;
  assign gap_sum = {1'b0, sh_q} + {1'b0, iv_i};

  // R3
  ptr_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (((gap_sum >= (ROW_W+1)'(N_ROWS)) ? gap_sum - (ROW_W+1)'(N_ROWS) : gap_sum)
                == {1'b0, rd_q}));
  // R2
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (rd_q < ROW_W'(N_ROWS) && sh_q < ROW_W'(N_ROWS)));
endmodule

// File: rtl/drs_row_driver.sv
module drs_row_driver
  import drs_pkg::*;
#(
  parameter int N_ROWS = 240,
  parameter int PW_MAX = 4,
  localparam int ROW_W = $clog2(N_ROWS),
  localparam int PW_W  = $clog2(PW_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  phase_e            ph_i,
  input  logic [PW_W-1:0]   cyc_i,
  input  logic [PW_W-1:0]   pw_i,
  input  logic [ROW_W-1:0]  rd_row_i,
  input  logic [ROW_W-1:0]  sh_row_i,
  output logic [N_ROWS-1:0] rst_o,
  output logic [N_ROWS-1:0] tx_o,
  output logic [N_ROWS-1:0] sel_o,
  output logic              smp_short_o,
  output logic              smp_reset_o,
  output logic              smp_long_o
);
  logic in_pulse, sel_win, smp_pt;
  logic rd_rst, rd_tx, sh_rst, sh_tx;
  logic [N_ROWS-1:0] rst_d, tx_d, sel_d;

  assign in_pulse = busy_i && (ph_i != PH_IDLE) && (cyc_i != pw_i);
  assign sel_win  = busy_i && ((ph_i == PH_RD_SIG) || (ph_i == PH_RD_RST) ||
                               ((ph_i == PH_RD_TX) && (cyc_i != pw_i)));
  assign smp_pt   = busy_i && (cyc_i == pw_i - PW_W'(1));
  assign rd_rst   = in_pulse && (ph_i == PH_RD_RST);
  assign rd_tx    = in_pulse && (ph_i == PH_RD_TX);
  assign sh_rst   = in_pulse && (ph_i == PH_SH_RST);
  assign sh_tx    = in_pulse && (ph_i == PH_SH_TX);

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    localparam logic [ROW_W-1:0] RIDX = ROW_W'(r);
    logic is_rd, is_sh;
    assign is_rd    = (rd_row_i == RIDX);
    assign is_sh    = (sh_row_i == RIDX);
    assign rst_d[r] = (is_rd && rd_rst) || (is_sh && sh_rst);
    assign tx_d[r]  = (is_rd && rd_tx)  || (is_sh && sh_tx);
    assign sel_d[r] = is_rd && sel_win;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_o       <= '0;
      tx_o        <= '0;
      sel_o       <= '0;
      smp_short_o <= 1'b0;
      smp_reset_o <= 1'b0;
      smp_long_o  <= 1'b0;
    end else begin
      rst_o       <= rst_d;
      tx_o        <= tx_d;
      sel_o       <= sel_d;
      smp_short_o <= smp_pt && (ph_i == PH_RD_SIG);
      smp_reset_o <= smp_pt && (ph_i == PH_RD_RST);
      smp_long_o  <= smp_pt && (ph_i == PH_RD_TX);
    end
  end

  // R3
  line_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($onehot0(rst_o) && $onehot0(tx_o) && $onehot0(sel_o)));
  // R4
  rst_tx_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|rst_o) && (|tx_o)));
  // R5
  smp_in_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_short_o || smp_reset_o || smp_long_o) |-> (|sel_o));
  // R5
  smp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({smp_short_o, smp_reset_o, smp_long_o}));
  // R5
  smp_short_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_short_o |=> !smp_short_o);
endmodule

// File: rtl/drs_row_seq.sv
module drs_row_seq
  import drs_pkg::*;
#(
  parameter int N_ROWS = 240,
  parameter int PW_MAX = 4,
  localparam int ROW_W = $clog2(N_ROWS),
  localparam int PW_W  = $clog2(PW_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [ROW_W-1:0]  interval_i,
  input  logic [PW_W-1:0]   pulse_w_i,
  output logic [N_ROWS-1:0] row_rst_o,
  output logic [N_ROWS-1:0] row_tx_o,
  output logic [N_ROWS-1:0] row_sel_o,
  output logic              smp_short_o,
  output logic              smp_reset_o,
  output logic              smp_long_o,
  output logic              frame_done_o
);
  logic             busy, start, slot_end, last_row;
  logic [ROW_W-1:0] iv_load, iv, rd_row, sh_row;
  logic [PW_W-1:0]  pw, cyc;
  phase_e           ph;

  drs_frame_ctrl #(.N_ROWS(N_ROWS), .PW_MAX(PW_MAX)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i     (frame_start_i),
    .interval_i,
    .pulse_w_i,
    .slot_end_i  (slot_end),
    .last_row_i  (last_row),
    .busy_o      (busy),
    .start_o     (start),
    .iv_load_o   (iv_load),
    .iv_o        (iv),
    .pw_o        (pw),
    .frame_done_o
  );

  drs_slot_timer #(.PW_MAX(PW_MAX)) u_timer (
    .clk_i, .rst_ni,
    .start_i    (start),
    .busy_i     (busy),
    .pw_i       (pw),
    .ph_o       (ph),
    .cyc_o      (cyc),
    .slot_end_o (slot_end)
  );

  drs_row_pointer #(.N_ROWS(N_ROWS)) u_ptr (
    .clk_i, .rst_ni,
    .start_i    (start),
    .busy_i     (busy),
    .slot_end_i (slot_end),
    .iv_load_i  (iv_load),
    .iv_i       (iv),
    .rd_row_o   (rd_row),
    .sh_row_o   (sh_row),
    .last_row_o (last_row)
  );

  drs_row_driver #(.N_ROWS(N_ROWS), .PW_MAX(PW_MAX)) u_drv (
    .clk_i, .rst_ni,
    .busy_i    (busy),
    .ph_i      (ph),
    .cyc_i     (cyc),
    .pw_i      (pw),
    .rd_row_i  (rd_row),
    .sh_row_i  (sh_row),
    .rst_o     (row_rst_o),
    .tx_o      (row_tx_o),
    .sel_o     (row_sel_o),
    .smp_short_o,
    .smp_reset_o,
    .smp_long_o
  );

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !frame_done_o) |=> (row_rst_o == '0 && row_tx_o == '0 && row_sel_o == '0));
endmodule

// File: tb/tb_drs_row_seq.sv
module tb_drs_row_seq;
  localparam int N  = 6;
  localparam int PM = 2;
  localparam int RW = $clog2(N);
  localparam int PWW = $clog2(PM + 1);
  localparam int S  = 5 * (PM + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0;
  logic [RW-1:0] iv_in = '0;
  logic [PWW-1:0] pw_in = '0;
  logic [N-1:0] rst_o, tx_o, sel_o;
  logic ss_o, sr_o, sl_o, done_o;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  drs_row_seq #(.N_ROWS(N), .PW_MAX(PM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs),
    .interval_i(iv_in), .pulse_w_i(pw_in),
    .row_rst_o(rst_o), .row_tx_o(tx_o), .row_sel_o(sel_o),
    .smp_short_o(ss_o), .smp_reset_o(sr_o), .smp_long_o(sl_o),
    .frame_done_o(done_o)
  );

  task automatic chk(string tag, string what, int g, logic [N-1:0] act, logic [N-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s g=%0d act=%h exp=%h", tag, what, g, act, exp);
    end
  endtask

  task automatic check_idle(string tag, int g);
    chk(tag, "rst", g, rst_o, '0);
    chk(tag, "tx", g, tx_o, '0);
    chk(tag, "sel", g, sel_o, '0);
    chk(tag, "strobes", g, N'({ss_o, sr_o, sl_o, done_o}), '0);
  endtask

  // run one frame; eiv/ep are the clamped values the model expects
  task automatic run_frame(string tag, int iv, int pw, int eiv, int ep, bit disturb);
    @(negedge clk);
    fs = 1'b1; iv_in = RW'(iv); pw_in = PWW'(pw);
    @(negedge clk);
    fs = 1'b0;
    check_idle("R1", -1);
    for (int g = 0; g <= N * S; g++) begin
      @(negedge clk);
      if (disturb && g == 20) begin
        fs = 1'b1; iv_in = RW'(N - 1 - eiv + 1); pw_in = PWW'(3 - ep);
      end else if (disturb && g == 21) begin
        fs = 1'b0;
      end
      if (g == N * S) begin
        check_idle("R7", g);
      end else begin
        int k = g / S;
        int t = g % S;
        int ph = t / (ep + 1);
        int c = t % (ep + 1);
        bit inp = (ph < 5) && (c < ep);
        int rd = k;
        int sh = (k + N - eiv) % N;
        logic [N-1:0] er = '0, et = '0, es = '0;
        if (ph == 1 && inp) er[rd] = 1'b1;
        if (ph == 3 && inp) er[sh] = 1'b1;
        if (ph == 2 && inp) et[rd] = 1'b1;
        if (ph == 4 && inp) et[sh] = 1'b1;
        if (ph <= 1 || (ph == 2 && c < ep)) es[rd] = 1'b1;
        chk({tag, "/R2/R3"}, "rst", g, rst_o, er);
        chk({tag, "/R2/R3"}, "tx", g, tx_o, et);
        chk({tag, "/R2"}, "sel", g, sel_o, es);
        chk({tag, "/R4"}, "rst&tx", g, rst_o & tx_o, '0);
        chk({tag, "/R5"}, "smp", g, N'({ss_o, sr_o, sl_o}),
            N'({ph == 0 && c == ep - 1, ph == 1 && c == ep - 1, ph == 2 && c == ep - 1}));
        chk({tag, "/R7"}, "done", g, N'(done_o), N'(g == N * S - 1));
      end
    end
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog R7 act=running exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1", -2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1", -3);
    run_frame("R2", 1, 1, 1, 1, 1'b0);
    run_frame("R3", 3, 2, 3, 2, 1'b0);
    run_frame("R3", 5, 2, 5, 2, 1'b0);
    run_frame("R7", 2, 1, 2, 1, 1'b1);
    run_frame("R6", 0, 2, 1, 2, 1'b0);
    run_frame("R6", 7, 1, 5, 1, 1'b0);
    run_frame("R6", 6, 0, 5, 1, 1'b0);
    run_frame("R6", 4, 3, 4, 2, 1'b1);
    repeat (5) @(negedge clk);
    check_idle("R1", -4);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule